// File: doc/BRIEF.md
# Conversion Result Byte-Pair Read Lock

This block stores a 10-bit conversion result and hands it to a processor as two 8-bit bytes, a low byte and a high byte. The processor reads them through separate strobes. The block makes sure that both bytes always come from the same conversion. A read of the low byte freezes the pair. A later read of the high byte unfreezes it. While the pair is frozen, any conversion that finishes is thrown away, but the completion interrupt still gets its set pulse. A processor that only needs 8 bits can select left alignment and read just the high byte. Such a high-byte-only read never freezes anything.

A two-state machine controls the lock. In state `ST_OPEN`, new results may be written. In state `ST_FROZEN`, all writes are refused. The transitions are:
- `T_FREEZE` (ST_OPEN to ST_FROZEN): taken on a low-byte read with no high-byte read in the same cycle.
- `T_RELEASE` (ST_FROZEN to ST_OPEN): taken on any high-byte read.
- `T_STAY_OPEN`: every other cycle in ST_OPEN. This includes a high-byte-only read and a cycle with both reads.
- `T_STAY_FROZEN`: every other cycle in ST_FROZEN. This includes a repeated low-byte read.

The alignment select is applied when the byte registers are written, not when they are read.

Top module: `adc_rdlock`

## Requirements
- R1: On a cycle with `res_done` high, the lock in ST_OPEN and `rd_lo` low, both bytes take the new result. The new bytes are visible from the next cycle on.
- R2: With `align_left` low when a result is written, `lo_byte` = result bits 7:0 and `hi_byte` = {6'b0, result bits 9:8}.
- R3: With `align_left` high when a result is written, `hi_byte` = result bits 9:2 and `lo_byte` = {result bits 1:0, 6'b0}.
- R4: Changing `align_left` without a completion leaves both bytes unchanged.
- R5: A `rd_lo` pulse (without `rd_hi`) in ST_OPEN enters ST_FROZEN. While frozen, a completion leaves both bytes unchanged.
- R6: A `rd_hi` pulse in ST_FROZEN returns to ST_OPEN, so the next completion updates the bytes.
- R7: Every `res_done` cycle produces a one-cycle `irq_set` pulse in the following cycle, whether the result was stored or discarded.
- R8: A `rd_hi` pulse in ST_OPEN, alone or together with `rd_lo`, keeps the block in ST_OPEN.
- R9: A completion in the same cycle as `rd_hi` while frozen is discarded, and the block still returns to ST_OPEN.
- R10: A completion in the same cycle as a lone `rd_lo` while open is discarded, and the block enters ST_FROZEN.
- R11: After reset, both bytes are zero, `irq_set` is low and the lock is in ST_OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 10 | Conversion result word |
| res_done | input | 1 | One-cycle conversion-complete strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| align_left | input | 1 | 1 = left-aligned result, 0 = right-aligned |
| lo_byte | output | 8 | Low byte register |
| hi_byte | output | 8 | High byte register |
| irq_set | output | 1 | Completion interrupt flag set pulse |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it:
- A stored result appears in `lo_byte` and `hi_byte` one edge after the completion strobe.
- The `irq_set` pulse appears at that same edge.
- A lock change shows up in how the following completion is handled.

The bench drives all inputs on the falling edge. It holds each strobe across a single rising edge and samples on the next falling edge, so every check lands in the one cycle where the result is due. Lock state is observed only through whether a later completion changes the bytes.

// File: rtl/adc_rdlock_pkg.sv
package adc_rdlock_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_FROZEN = 1'b1
    } lock_state_e;

endpackage

// File: rtl/adc_rdlock_align.sv
module adc_rdlock_align #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  res_in,
    input  logic              left,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);

    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] pair_right;
    logic [PAIR_W-1:0] pair_left;
    logic [PAIR_W-1:0] pair_sel;

    generate
        if (PAD_W == 0) begin : g_nopad
            assign pair_right = res_in;
            assign pair_left  = res_in;
        end else begin : g_pad
            assign pair_right = {{PAD_W{1'b0}}, res_in};
            assign pair_left  = {res_in, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        pair_sel = left ? pair_left : pair_right;
        lo_out   = pair_sel[BYTE_W-1:0];
        hi_out   = pair_sel[PAIR_W-1:BYTE_W];
    end

endmodule

// File: rtl/adc_rdlock_fsm.sv
module adc_rdlock_fsm
    import adc_rdlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_done,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic wr_en,
    output logic blocked,
    output logic irq_set
);

    lock_state_e state_q;
    lock_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (rd_lo && !rd_hi) state_d = ST_FROZEN;      // T_FREEZE
                else                 state_d = ST_OPEN;        // T_STAY_OPEN
            end
            ST_FROZEN: begin
                if (rd_hi) state_d = ST_OPEN;                  // T_RELEASE
                else       state_d = ST_FROZEN;                // T_STAY_FROZEN
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        blocked = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                wr_en = res_done && !rd_lo;
            end
            ST_FROZEN: begin
                blocked = 1'b1;
            end
            default: begin
                blocked = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_set <= 1'b0;
        else        irq_set <= res_done;
    end

    // R5: a lone low-byte read while open freezes the pair
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && rd_lo && !rd_hi) |=> blocked);

    // R6: any high-byte read while frozen releases
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && rd_hi) |=> !blocked);

    // R8: a high-byte read while open never freezes
    a_r8_hi_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && rd_hi) |=> !blocked);

    // R7: one interrupt set pulse per completion
    a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> irq_set);
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |=> !irq_set);

endmodule

// File: rtl/adc_rdlock_bank.sv
module adc_rdlock_bank #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
        end
    end

endmodule

// File: rtl/adc_rdlock.sv
module adc_rdlock #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_done,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              align_left,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              irq_set
);

    localparam int HI_SPILL = RES_W - BYTE_W;

    logic              wr_en;
    logic              blocked;
    logic [BYTE_W-1:0] lo_fmt;
    logic [BYTE_W-1:0] hi_fmt;

    adc_rdlock_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
        .res_in (res_data),
        .left   (align_left),
        .lo_out (lo_fmt),
        .hi_out (hi_fmt)
    );

    adc_rdlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_done (res_done),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .wr_en    (wr_en),
        .blocked  (blocked),
        .irq_set  (irq_set)
    );

    adc_rdlock_bank #(.BYTE_W(BYTE_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .lo_in (lo_fmt),
        .hi_in (hi_fmt),
        .lo_q  (lo_byte),
        .hi_q  (hi_byte)
    );

    // R5: completion while frozen leaves both bytes untouched
    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && res_done) |=> ($stable(lo_byte) && $stable(hi_byte)));

    // R10: completion colliding with a low-byte read is discarded
    a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && rd_lo && res_done) |=> ($stable(lo_byte) && $stable(hi_byte)));

    // R2: right-aligned store puts the low bits straight into the low byte
    a_r2_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && res_done && !rd_lo && !align_left)
        |=> (lo_byte == $past(res_data[BYTE_W-1:0])
             && (hi_byte >> HI_SPILL) == '0));

    // R3: left-aligned store puts the top bits in the high byte
    a_r3_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && res_done && !rd_lo && align_left)
        |=> (hi_byte == $past(res_data[RES_W-1:HI_SPILL])));

    // R4: no completion, no byte change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |=> ($stable(lo_byte) && $stable(hi_byte)));

endmodule

// File: tb/adc_rdlock_tb.sv
module adc_rdlock_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] res_data;
    logic       res_done;
    logic       rd_lo;
    logic       rd_hi;
    logic       align_left;
    logic [7:0] lo_byte;
    logic [7:0] hi_byte;
    logic       irq_set;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    adc_rdlock u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_data   (res_data),
        .res_done   (res_done),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .align_left (align_left),
        .lo_byte    (lo_byte),
        .hi_byte    (hi_byte),
        .irq_set    (irq_set)
    );

    // {align_left, result[9:0], expected hi, expected lo}
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 10'h3FF, 8'h03, 8'hFF},
        {1'b0, 10'h155, 8'h01, 8'h55},
        {1'b1, 10'h3FF, 8'hFF, 8'hC0},
        {1'b1, 10'h155, 8'h55, 8'h40},
        {1'b0, 10'h2AA, 8'h02, 8'hAA},
        {1'b1, 10'h2AA, 8'hAA, 8'h80},
        {1'b1, 10'h001, 8'h00, 8'h40},
        {1'b0, 10'h000, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on falling edge, hold across one rising edge, return at the next falling edge
    task automatic step(input logic done, input logic [9:0] d, input logic al,
                        input logic lo, input logic hi);
        res_data   = d;
        res_done   = done;
        align_left = al;
        rd_lo      = lo;
        rd_hi      = hi;
        @(negedge clk);
        res_done = 1'b0;
        rd_lo    = 1'b0;
        rd_hi    = 1'b0;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; res_data = '0; res_done = 1'b0;
        rd_lo = 1'b0; rd_hi = 1'b0; align_left = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 lo", lo_byte, 8'h00);
        check("R11 hi", hi_byte, 8'h00);
        check("R11 irq", {7'b0, irq_set}, 8'h00);

        // vector table: R1, R2, R3, R7
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][25:16], VEC[i][26], 1'b0, 1'b0);
            check(VEC[i][26] ? "R3 hi" : "R2 hi", hi_byte, VEC[i][15:8]);
            check(VEC[i][26] ? "R3 lo" : "R2 lo", lo_byte, VEC[i][7:0]);
            check("R7 irq", {7'b0, irq_set}, 8'h01);
            step(1'b0, '0, VEC[i][26], 1'b1, 1'b0);
            check("R7 irq low", {7'b0, irq_set}, 8'h00);
            step(1'b0, '0, VEC[i][26], 1'b0, 1'b1);
            check("R1 stable", lo_byte, VEC[i][7:0]);
        end

        // R4: alignment applied at write time
        step(1'b1, 10'h2C3, 1'b0, 1'b0, 1'b0);   // hi 02 lo C3
        step(1'b0, '0, 1'b1, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check("R4 hi", hi_byte, 8'h02);
        check("R4 lo", lo_byte, 8'hC3);

        // R5: freeze then discard
        step(1'b0, '0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 10'h111, 1'b0, 1'b0, 1'b0);
        check("R5 lo", lo_byte, 8'hC3);
        check("R5 hi", hi_byte, 8'h02);
        check("R7 irq dropped", {7'b0, irq_set}, 8'h01);
        step(1'b0, '0, 1'b0, 1'b1, 1'b0);          // repeated low read stays frozen
        step(1'b1, 10'h222, 1'b0, 1'b0, 1'b0);
        check("R5 refrozen lo", lo_byte, 8'hC3);

        // R6: release then update
        step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 10'h1A5, 1'b0, 1'b0, 1'b0);
        check("R6 lo", lo_byte, 8'hA5);
        check("R6 hi", hi_byte, 8'h01);

        // R8: high-only read while open
        step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 10'h07E, 1'b0, 1'b0, 1'b0);
        check("R8 hi-only lo", lo_byte, 8'h7E);
        // R8: both reads together while open
        step(1'b0, '0, 1'b0, 1'b1, 1'b1);
        step(1'b1, 10'h381, 1'b0, 1'b0, 1'b0);
        check("R8 both lo", lo_byte, 8'h81);
        check("R8 both hi", hi_byte, 8'h03);

        // R9: completion with release while frozen
        step(1'b0, '0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 10'h0F0, 1'b0, 1'b0, 1'b1);
        check("R9 discarded lo", lo_byte, 8'h81);
        check("R7 irq R9", {7'b0, irq_set}, 8'h01);
        step(1'b1, 10'h0F0, 1'b0, 1'b0, 1'b0);
        check("R9 released lo", lo_byte, 8'hF0);
        check("R9 released hi", hi_byte, 8'h00);

        // R10: completion colliding with low read while open
        step(1'b1, 10'h3C3, 1'b0, 1'b1, 1'b0);
        check("R10 discarded lo", lo_byte, 8'hF0);
        step(1'b1, 10'h3C3, 1'b0, 1'b0, 1'b0);
        check("R10 frozen lo", lo_byte, 8'hF0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 10'h3C3, 1'b1, 1'b0, 1'b0);
        check("R10 after release hi", hi_byte, 8'hF0);
        check("R10 after release lo", lo_byte, 8'hC0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule